// File: doc/BRIEF.md
# Page-Write Load Controller

This block is a synchronous front end for a byte-wide nonvolatile memory model. The host issues byte writes one clock at a time with a strobe, an address and a data byte. The first write of a burst fixes the target page. Later writes to that same page are gathered into a page buffer, and each buffered byte is marked by its own valid flag. Every accepted byte restarts an inactivity window. When the window runs out with no further byte, the block starts an internally timed programming cycle by itself. There is no explicit commit command.

During the programming cycle the active-low ready/busy output is held low. Only the bytes that were actually loaded are copied into the array, and the valid flags are then cleared. A lone byte write takes the same path as a one-byte page. The array is a behavioural RAM with a separate combinational read port. Its contents start as all ones and are never touched by reset.

Top module: `page_load_ctrl`

## Requirements
- R1: After reset `busy_n` is 1, and a freshly started array reads FFh at every one of its 8192 addresses.
- R2: When a byte is accepted at clock edge E and no other byte is accepted afterwards, `busy_n` first reads 0 after edge E+WIN_CYC.
- R3: A byte accepted while a load is open restarts the window, even when it lands on the last window cycle. `busy_n` stays 1 until WIN_CYC edges after the latest accepted byte.
- R4: Address bits 12..6 form the page number and bits 5..0 the byte offset. A strobe whose page differs from the page of the first byte of the load is ignored: it does not restart the window and it is not written.
- R5: `busy_n` stays 0 for exactly PROG_CYC clock cycles. When it returns to 1 the array already holds the new data.
- R6: Strobes that arrive while `busy_n` is 0 are ignored. They do not lengthen the programming cycle, do not open a new load afterwards and change no array byte.
- R7: A commit writes only the loaded bytes of the page and leaves every other array byte unchanged. The valid flags are cleared afterwards, so a later load never carries over bytes from an earlier one.
- R8: When one offset is written more than once within a load, the last value written is the one committed.
- R9: A single byte write is committed through the same window and programming timing as a multi-byte page.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset of the control state |
| wr_stb | input | 1 | Byte write request, sampled on each rising edge |
| wr_addr | input | 13 | Write address: bits 12..6 give the page, bits 5..0 the offset |
| wr_data | input | 8 | Write data byte |
| rd_addr | input | 13 | Read address of the array |
| rd_data | output | 8 | Array contents at `rd_addr`, combinational |
| busy_n | output | 1 | Low during the internal programming cycle |

## Verification
A wrong window count moves the falling edge of `busy_n` away from WIN_CYC cycles after the last accepted byte. A wrong busy count changes how long `busy_n` stays low. Both errors show up on the first burst, to the exact cycle. A stale valid flag or a wrongly latched page number only appears in the array, so the bench reads back all 8192 addresses after each scenario and compares them with a reference model. Any byte written where it should not be, or missing where it should be, is therefore caught before the next burst starts.

// File: rtl/plc_pkg.sv
// Package: shared types for the page-write load controller.
// Assumes: nothing beyond IEEE 1800-2017.
package plc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // no load open
        ST_LOAD = 2'd1,   // gathering bytes, window running
        ST_PROG = 2'd2    // internal programming cycle
    } plc_state_e;
endpackage

// File: rtl/plc_down_timer.sv
// Module: reloadable down counter used for the load window and the busy cycle.
// Assumes: LENGTH >= 1; start has priority over counting.
module plc_down_timer #(
    parameter int unsigned LENGTH = 16,
    localparam int unsigned CW = $clog2(LENGTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic [CW-1:0] cnt,
    output logic          last
);
    // Reload on start, otherwise count down to zero and stay there.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (start)
            cnt <= CW'(LENGTH);
        else if (cnt != '0)
            cnt <= cnt - CW'(1);
    end

    // Final counted cycle.
    assign last = (cnt == CW'(1));
endmodule

// File: rtl/plc_page_buffer.sv
// Module: page buffer with per-byte valid flags and the latched page number.
// Assumes: clr and wr_en are never high together.
module plc_page_buffer #(
    parameter int unsigned OFS_W  = 6,
    parameter int unsigned PAGE_W = 7,
    parameter int unsigned DATA_W = 8,
    localparam int unsigned NB = 1 << OFS_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic                       capture,
    input  logic                       clr,
    input  logic [PAGE_W-1:0]          wr_page,
    input  logic [OFS_W-1:0]           wr_ofs,
    input  logic [DATA_W-1:0]          wr_data,
    output logic [PAGE_W-1:0]          page_q,
    output logic [NB-1:0][DATA_W-1:0]  data_q,
    output logic [NB-1:0]              valid_q
);
    // Valid flags: set per loaded byte, cleared after a commit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            valid_q <= '0;
        else if (clr)
            valid_q <= '0;
        else if (wr_en)
            valid_q[wr_ofs] <= 1'b1;
    end

    // Byte storage: a later write to the same offset replaces the earlier one.
    always_ff @(posedge clk) begin
        if (wr_en)
            data_q[wr_ofs] <= wr_data;
    end

    // Page number taken from the first byte of a load.
    always_ff @(posedge clk) begin
        if (!rst_n)
            page_q <= '0;
        else if (capture)
            page_q <= wr_page;
    end
endmodule

// File: rtl/plc_array.sv
// Module: behavioural byte array with a page-wide masked commit port.
// Assumes: contents start at all ones and survive reset (nonvolatile model).
module plc_array #(
    parameter int unsigned ADDR_W = 13,
    parameter int unsigned OFS_W  = 6,
    parameter int unsigned DATA_W = 8,
    localparam int unsigned NB     = 1 << OFS_W,
    localparam int unsigned DEPTH  = 1 << ADDR_W,
    localparam int unsigned PAGE_W = ADDR_W - OFS_W
) (
    input  logic                       clk,
    input  logic                       commit,
    input  logic [PAGE_W-1:0]          page,
    input  logic [NB-1:0][DATA_W-1:0]  buf_data,
    input  logic [NB-1:0]              buf_valid,
    input  logic [ADDR_W-1:0]          rd_addr,
    output logic [DATA_W-1:0]          rd_data
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Power-up contents: every byte erased.
    initial begin
        for (int a = 0; a < int'(DEPTH); a++)
            mem[a] = '1;
    end

    // Commit: copy only the flagged buffer bytes into the selected page.
    always_ff @(posedge clk) begin
        if (commit) begin
            for (int i = 0; i < int'(NB); i++) begin
                if (buf_valid[i])
                    mem[{page, OFS_W'(i)}] <= buf_data[i];
            end
        end
    end

    // Asynchronous read port.
    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/page_load_ctrl.sv
// Module: page-write load controller (top).
// Gathers same-page byte writes, then commits them in a timed programming
// cycle once an inactivity window of WIN_CYC clocks expires.
// Assumes: WIN_CYC >= 1, PROG_CYC >= 1, ADDR_W > OFS_W.
module page_load_ctrl #(
    parameter int unsigned ADDR_W   = 13,
    parameter int unsigned OFS_W    = 6,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned WIN_CYC  = 32,
    parameter int unsigned PROG_CYC = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy_n
);
    import plc_pkg::*;

    localparam int unsigned PAGE_W = ADDR_W - OFS_W;
    localparam int unsigned NB     = 1 << OFS_W;
    localparam int unsigned WCW    = $clog2(WIN_CYC + 1);
    localparam int unsigned PCW    = $clog2(PROG_CYC + 1);

    plc_state_e               state_q;
    logic [PAGE_W-1:0]        wr_page;
    logic [OFS_W-1:0]         wr_ofs;
    logic [PAGE_W-1:0]        page_q;
    logic [NB-1:0][DATA_W-1:0] buf_data;
    logic [NB-1:0]            valid_q;
    logic                     accept, first_byte, go_prog, commit;
    logic [WCW-1:0]           win_cnt;
    logic [PCW-1:0]           busy_cnt;
    logic                     win_last, busy_last;

    assign wr_page = wr_addr[ADDR_W-1:OFS_W];
    assign wr_ofs  = wr_addr[OFS_W-1:0];

    // Strobe qualification: open a load when idle, extend it only for the same page.
    always_comb begin
        first_byte = wr_stb && (state_q == ST_IDLE);
        accept     = first_byte ||
                     (wr_stb && (state_q == ST_LOAD) && (wr_page == page_q));
        go_prog    = (state_q == ST_LOAD) && win_last && !accept;
        commit     = (state_q == ST_PROG) && busy_last;
    end

    // Control state: idle -> load -> program -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else if (first_byte)
            state_q <= ST_LOAD;
        else if (go_prog)
            state_q <= ST_PROG;
        else if (commit)
            state_q <= ST_IDLE;
    end

    assign busy_n = (state_q != ST_PROG);

    plc_down_timer #(.LENGTH(WIN_CYC)) u_win_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (accept),
        .cnt   (win_cnt),
        .last  (win_last)
    );

    plc_down_timer #(.LENGTH(PROG_CYC)) u_busy_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (go_prog),
        .cnt   (busy_cnt),
        .last  (busy_last)
    );

    plc_page_buffer #(.OFS_W(OFS_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (accept),
        .capture (first_byte),
        .clr     (commit),
        .wr_page (wr_page),
        .wr_ofs  (wr_ofs),
        .wr_data (wr_data),
        .page_q  (page_q),
        .data_q  (buf_data),
        .valid_q (valid_q)
    );

    plc_array #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .DATA_W(DATA_W)) u_mem (
        .clk       (clk),
        .commit    (commit),
        .page      (page_q),
        .buf_data  (buf_data),
        .buf_valid (valid_q),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data)
    );
endmodule

// File: rtl/plc_checker.sv
// Module: protocol checker for page_load_ctrl, attached by bind.
// Assumes: observes the top's state, timer counts and buffer flags.
module plc_checker #(
    parameter int unsigned ADDR_W   = 13,
    parameter int unsigned OFS_W    = 6,
    parameter int unsigned WIN_CYC  = 32,
    parameter int unsigned PROG_CYC = 256,
    localparam int unsigned PAGE_W = ADDR_W - OFS_W,
    localparam int unsigned NB     = 1 << OFS_W,
    localparam int unsigned WCW    = $clog2(WIN_CYC + 1),
    localparam int unsigned PCW    = $clog2(PROG_CYC + 1)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_stb,
    input logic [ADDR_W-1:0]    wr_addr,
    input logic                 busy_n,
    input plc_pkg::plc_state_e  state_q,
    input logic [PAGE_W-1:0]    page_q,
    input logic                 accept,
    input logic [WCW-1:0]       win_cnt,
    input logic [PCW-1:0]       busy_cnt,
    input logic [NB-1:0]        valid_q
);
    import plc_pkg::*;

    AST_RESET_READY: assert property (@(posedge clk)
        !rst_n |=> busy_n);                                                  // R1

    AST_BUSY_AFTER_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_n) |-> ($past(win_cnt) == WCW'(1) && $past(state_q) == ST_LOAD)); // R2

    AST_WINDOW_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (win_cnt == WCW'(WIN_CYC)));                              // R3

    AST_FOREIGN_PAGE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD && wr_stb && wr_addr[ADDR_W-1:OFS_W] != page_q) |-> !accept); // R4

    AST_BUSY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_n && busy_cnt > PCW'(1)) |=> !busy_n);                        // R5

    AST_BUSY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_n) |-> $past(busy_cnt) == PCW'(1));                       // R5

    AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_n |-> !accept);                                                // R6

    AST_FLAGS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_n) |-> (valid_q == '0));                                  // R7
endmodule

bind page_load_ctrl plc_checker #(
    .ADDR_W(ADDR_W), .OFS_W(OFS_W), .WIN_CYC(WIN_CYC), .PROG_CYC(PROG_CYC)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_stb   (wr_stb),
    .wr_addr  (wr_addr),
    .busy_n   (busy_n),
    .state_q  (state_q),
    .page_q   (page_q),
    .accept   (accept),
    .win_cnt  (win_cnt),
    .busy_cnt (busy_cnt),
    .valid_q  (valid_q)
);

// File: tb/page_load_ctrl_test.sv
module page_load_ctrl_test;
    localparam int WIN  = 4;
    localparam int PROG = 6;
    localparam int DEPTH = 8192;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_stb = 1'b0;
    logic [12:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [12:0] rd_addr = '0;
    logic [7:0]  rd_data;
    logic        busy_n;

    int vectors = 0;
    int errors  = 0;

    logic [7:0] ref_mem [DEPTH];
    logic [7:0] pend_d  [64];
    logic       pend_v  [64];
    logic [6:0] pend_pg;

    page_load_ctrl #(.WIN_CYC(WIN), .PROG_CYC(PROG)) uut (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .busy_n(busy_n)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference model: record an expected load, then apply it on commit.
    task automatic model_put(input logic [12:0] a, input logic [7:0] d);
        pend_pg = a[12:6];
        pend_d[a[5:0]] = d;
        pend_v[a[5:0]] = 1'b1;
    endtask

    task automatic model_commit();
        for (int i = 0; i < 64; i++) begin
            if (pend_v[i]) ref_mem[{pend_pg, 6'(i)}] = pend_d[i];
            pend_v[i] = 1'b0;
        end
    endtask

    // Called at a negedge: one-cycle strobe, returns at the following negedge.
    task automatic do_write(input logic [12:0] a, input logic [7:0] d);
        wr_stb = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic wait_busy(input int exp, input string tag);
        int n = 0;
        while (busy_n && n < 1000) begin @(negedge clk); n++; end
        check(n == exp, tag, n, exp);
    endtask

    task automatic busy_len(input int exp, input string tag);
        int m = 0;
        while (!busy_n && m < 1000) begin @(negedge clk); m++; end
        check(m == exp, tag, m, exp);
    endtask

    task automatic sweep(input string tag);
        for (int a = 0; a < DEPTH; a++) begin
            rd_addr = 13'(a);
            #1;
            check(rd_data == ref_mem[a], tag, rd_data, ref_mem[a]);
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        for (int a = 0; a < DEPTH; a++) ref_mem[a] = 8'hFF;
        for (int i = 0; i < 64; i++) pend_v[i] = 1'b0;
        pend_pg = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state and erased array
        check(busy_n == 1'b1, "R1 busy_n after reset", busy_n, 1);
        sweep("R1 erased contents");

        // R9 / R2 / R5: single byte write
        do_write(13'h0ABC, 8'h5A); model_put(13'h0ABC, 8'h5A);
        wait_busy(WIN, "R2 R9 single byte window");
        busy_len(PROG, "R5 R9 single byte busy length");
        model_commit();
        sweep("R7 R9 single byte contents");

        // R2 / R5: full page, back-to-back strobes
        for (int i = 0; i < 64; i++) begin
            do_write({7'h15, 6'(i)}, 8'((i * 37 + 11) ^ 8'hC3));
            model_put({7'h15, 6'(i)}, 8'((i * 37 + 11) ^ 8'hC3));
        end
        wait_busy(WIN, "R2 full page window");
        busy_len(PROG, "R5 full page busy length");
        model_commit();
        sweep("R7 full page contents");

        // R3: restart on the last window cycle
        for (int k = 0; k < 3; k++) begin
            do_write({7'h40, 6'(k * 5)}, 8'(8'h90 + k));
            model_put({7'h40, 6'(k * 5)}, 8'(8'h90 + k));
            if (k < 2) begin
                for (int g = 0; g < WIN - 1; g++) begin
                    check(busy_n == 1'b1, "R3 busy_n during restarted window", busy_n, 1);
                    @(negedge clk);
                end
            end
        end
        wait_busy(WIN, "R3 window after last restart");
        busy_len(PROG, "R5 restart busy length");
        model_commit();
        sweep("R3 restart contents");

        // R4: foreign page ignored, no restart
        do_write({7'h02, 6'd9}, 8'h33); model_put({7'h02, 6'd9}, 8'h33);
        @(negedge clk);
        do_write({7'h03, 6'd9}, 8'h44);
        wait_busy(WIN - 2, "R4 foreign page does not restart");
        busy_len(PROG, "R5 foreign case busy length");
        model_commit();
        sweep("R4 foreign page not written");

        // R8: repeated offset, last value wins
        do_write({7'h07, 6'd4}, 8'h10);
        do_write({7'h07, 6'd4}, 8'h20); model_put({7'h07, 6'd4}, 8'h20);
        wait_busy(WIN, "R8 window");
        busy_len(PROG, "R8 busy length");
        model_commit();
        sweep("R8 last value committed");

        // R6: strobes during programming ignored
        do_write({7'h10, 6'd1}, 8'h77); model_put({7'h10, 6'd1}, 8'h77);
        wait_busy(WIN, "R6 window");
        do_write({7'h10, 6'd2}, 8'h88);
        begin
            int m = 0;
            while (!busy_n && m < 1000) begin @(negedge clk); m++; end
            check(m + 1 == PROG, "R6 busy length with strobe inside", m + 1, PROG);
        end
        model_commit();
        for (int g = 0; g < WIN + 2; g++) begin
            check(busy_n == 1'b1, "R6 no load opened by ignored strobe", busy_n, 1);
            @(negedge clk);
        end
        sweep("R6 ignored strobe not written");

        // R7: valid flags cleared between loads
        do_write({7'h20, 6'd3}, 8'h11); model_put({7'h20, 6'd3}, 8'h11);
        wait_busy(WIN, "R7 first load window");
        busy_len(PROG, "R7 first load busy length");
        model_commit();
        do_write({7'h21, 6'd5}, 8'h99); model_put({7'h21, 6'd5}, 8'h99);
        wait_busy(WIN, "R7 second load window");
        busy_len(PROG, "R7 second load busy length");
        model_commit();
        sweep("R7 no carried-over bytes");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule